// File: doc/BRIEF.md
# Commutation PWM Timer

The block is a timer that drives six motor-commutation pins from one shared pulse-width waveform. An internal counter runs either as a sawtooth (up from 0 to a period value, then back to 0) or as a triangle (up to the period value, then down to 0). A single buffered compare value is checked against the counter to form one waveform level. That level goes to all six pins at once. A two-bit polarity field passes the level straight, inverts it, or disconnects it.

A six-bit override mask picks, pin by pin and with no clock delay, whether a pin carries the waveform or a fallback bit from a port register. Commutation firmware switches the active phases by rewriting this mask. Each counting cycle raises a sticky overflow flag, which firmware clears by writing 1, and an interrupt is formed from that flag and an enable bit.

The counter direction is held in a two-state machine, CNT_UP and CNT_DOWN:
- In sawtooth mode the machine stays in CNT_UP and wraps to 0 at the period value. From CNT_DOWN, switching to sawtooth mode returns it to CNT_UP with the counter at 0.
- In triangle mode, CNT_UP moves to CNT_DOWN when the counter reaches the period value. CNT_DOWN moves to CNT_UP when the counter reaches 0.

Top module: `commutation_pwm`

## Requirements
- R1: With `dual_slope`=0 the counter counts 0,1,…,`period`, then 0 again; one period lasts `period`+1 cycles (`period` ≥ 1).
- R2: With `dual_slope`=1 the counter counts 0,1,…,`period`,`period`-1,…,0 and repeats; one period lasts 2·`period` cycles.
- R3: Sawtooth waveform level (polarity 10) is 1 while counter < active compare and 0 otherwise. An active compare of 0 gives a constant 0, and an active compare ≥ `period` gives a constant 1.
- R4: Triangle waveform level (polarity 10) is 1 while counter ≥ active compare and 0 otherwise. An active compare of 0 gives a constant 1, and an active compare ≥ `period` gives a constant 0.
- R5: `pol_mode` 00 makes every pin equal its `port_bits` bit; 10 drives the level of R3/R4; 11 drives its inverse; 01 behaves as 10.
- R6: With polarity not 00, `pins[i]` is the waveform level when `ovr_en[i]`=1 and `port_bits[i]` when `ovr_en[i]`=0, with no clock delay after either input changes.
- R7: A `cmp_wr` pulse stores `cmp_data` in a pending register. The pending value becomes active on the clock edge taken while the counter equals `period` (sawtooth) or 0 (triangle), so a running period is never altered. Both registers reset to 0.
- R8: `ovf_flag` rises one cycle after the counter equals `period` in sawtooth mode, and one cycle after the counter reaches 0 while counting down in triangle mode.
- R9: `ovf_flag` stays set until an edge with `ovf_clr`=1. When a new overflow and `ovf_clr` fall on the same edge, the flag stays set.
- R10: `irq` is 1 exactly when `ovf_flag` and `irq_en` are both 1, with no clock delay after `irq_en` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_slope | input | 1 | 0 = sawtooth counting, 1 = triangle counting |
| pol_mode | input | 2 | Polarity: 00 disconnect, 01/10 straight, 11 inverted |
| period | input | CW | TOP value of the counter |
| cmp_wr | input | 1 | Write strobe for the pending compare value |
| cmp_data | input | CW | New compare value |
| ovr_en | input | 6 | Per-pin waveform enable; 0 selects the port bit |
| port_bits | input | 6 | Fallback pin values |
| ovf_clr | input | 1 | Clears the overflow flag (write-1-to-clear) |
| irq_en | input | 1 | Interrupt enable |
| pins | output | 6 | Commutation outputs |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value or a wrong direction state appears on the pins within one period, because the waveform level is a direct function of the counter. A sweep over every compare value, including 0, `period` and `period`+1, against several small periods exposes it. A compare value that loads at the wrong moment shifts an edge inside the period where it was written; this is caught in the cycles just after the write. A flag that sets one cycle early or late, or that is lost when a clear collides with a new overflow, shows on `ovf_flag` and `irq` in the very next sample.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic [0:0] {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    localparam int NPINS = 6;

    localparam logic [1:0] POL_OFF = 2'b00;
    localparam logic [1:0] POL_INV = 2'b11;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_slope,
    input  logic [CW-1:0] period,
    input  logic          cmp_wr,
    input  logic [CW-1:0] cmp_data,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cmp_act,
    output logic          ovf_evt
);
    cnt_dir_e      st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] pend_q;
    logic          at_top;
    logic          at_zero;
    logic          upd;

    assign at_top  = (cnt_q >= period);
    assign at_zero = (cnt_q == '0);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            CNT_UP: begin
                if (!dual_slope) begin
                    cnt_n = at_top ? '0 : cnt_q + 1'b1;
                end else if (period == '0) begin
                    cnt_n = '0;
                end else if (at_top) begin
                    st_n  = CNT_DOWN;
                    cnt_n = cnt_q - 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            CNT_DOWN: begin
                if (!dual_slope) begin
                    st_n  = CNT_UP;
                    cnt_n = '0;
                end else if (at_zero) begin
                    st_n  = CNT_UP;
                    cnt_n = (period == '0) ? '0 : {{(CW-1){1'b0}}, 1'b1};
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: begin
                st_n  = CNT_UP;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CNT_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign upd     = dual_slope ? at_zero : at_top;
    assign ovf_evt = dual_slope ? (st_q == CNT_DOWN && at_zero) : at_top;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            cmp_act <= '0;
        end else begin
            if (cmp_wr) pend_q <= cmp_data;
            if (upd)    cmp_act <= pend_q;
        end
    end

    assign cnt = cnt_q;

    // R1
    saw_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_slope && cnt_q >= period) |=> (cnt_q == '0));

    // R2
    tri_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_slope && st_q == CNT_DOWN && at_zero && period != '0) |=> (st_q == CNT_UP && cnt_q != '0));

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(cmp_act));
endmodule

// File: rtl/cpwm_wave.sv
module cpwm_wave
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          dual_slope,
    input  logic [1:0]    pol_mode,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp_act,
    output logic          wave,
    output logic          drive_en
);
    logic base;

    always_comb begin
        if (!dual_slope) begin
            base = (cmp_act >= period) ? 1'b1 : (cnt < cmp_act);
        end else begin
            base = (cmp_act >= period) ? 1'b0 : (cnt >= cmp_act);
        end
    end

    assign wave     = (pol_mode == POL_INV) ? ~base : base;
    assign drive_en = (pol_mode != POL_OFF);
endmodule

// File: rtl/cpwm_pinmux.sv
module cpwm_pinmux
    import cpwm_pkg::*;
#(
    parameter int NP = NPINS
) (
    input  logic          wave,
    input  logic          drive_en,
    input  logic [NP-1:0] ovr_en,
    input  logic [NP-1:0] port_bits,
    output logic [NP-1:0] pins
);
    for (genvar i = 0; i < NP; i++) begin : g_pin
        assign pins[i] = (drive_en && ovr_en[i]) ? wave : port_bits[i];
    end
endmodule

// File: rtl/commutation_pwm.sv
module commutation_pwm
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_slope,
    input  logic [1:0]    pol_mode,
    input  logic [CW-1:0] period,
    input  logic          cmp_wr,
    input  logic [CW-1:0] cmp_data,
    input  logic [5:0]    ovr_en,
    input  logic [5:0]    port_bits,
    input  logic          ovf_clr,
    input  logic          irq_en,
    output logic [5:0]    pins,
    output logic          ovf_flag,
    output logic          irq
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cmp_act;
    logic          ovf_evt;
    logic          wave;
    logic          drive_en;
    logic          flag_q;

    cpwm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .dual_slope(dual_slope), .period(period),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data), .cnt(cnt), .cmp_act(cmp_act),
        .ovf_evt(ovf_evt)
    );

    cpwm_wave #(.CW(CW)) u_wave (
        .dual_slope(dual_slope), .pol_mode(pol_mode), .period(period),
        .cnt(cnt), .cmp_act(cmp_act), .wave(wave), .drive_en(drive_en)
    );

    cpwm_pinmux #(.NP(NPINS)) u_mux (
        .wave(wave), .drive_en(drive_en), .ovr_en(ovr_en),
        .port_bits(port_bits), .pins(pins)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= ovf_evt | (flag_q & ~ovf_clr);
    end

    assign ovf_flag = flag_q;
    assign irq      = flag_q & irq_en;

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R3
    saw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_slope && cmp_act == '0 && pol_mode == 2'b10 && ovr_en[0]) |-> !pins[0]);
endmodule

// File: tb/tb_commutation_pwm.sv
module tb_commutation_pwm;
    localparam int CW    = 4;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dual_slope;
    logic [1:0]    pol_mode;
    logic [CW-1:0] period;
    logic          cmp_wr;
    logic [CW-1:0] cmp_data;
    logic [5:0]    ovr_en;
    logic [5:0]    port_bits;
    logic          ovf_clr;
    logic          irq_en;
    logic [5:0]    pins;
    logic          ovf_flag;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    commutation_pwm #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .dual_slope(dual_slope), .pol_mode(pol_mode),
        .period(period), .cmp_wr(cmp_wr), .cmp_data(cmp_data), .ovr_en(ovr_en),
        .port_bits(port_bits), .ovf_clr(ovf_clr), .irq_en(irq_en),
        .pins(pins), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int cnt_at(int n, int dual, int top);
        int k;
        if (dual == 0) return n % (top + 1);
        k = n % (2 * top);
        return (k <= top) ? k : 2 * top - k;
    endfunction

    function automatic logic lvl(int c, int cmp, int dual, int top, int pol);
        logic b;
        if (dual == 0) b = (cmp >= top) ? 1'b1 : (c < cmp);
        else           b = (cmp >= top) ? 1'b0 : (c >= cmp);
        return (pol == 3) ? ~b : b;
    endfunction

    function automatic logic [5:0] exp_pins(logic w, int pol, logic [5:0] en, logic [5:0] pb);
        if (pol == 0) return pb;
        return (en & {6{w}}) | (~en & pb);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic start(int dual, int top, int pol, int cmp);
        rst_n = 1'b0; cmp_wr = 1'b0; cmp_data = '0; ovf_clr = 1'b1; irq_en = 1'b1;
        ovr_en = 6'h3F; port_bits = 6'h00;
        dual_slope = dual[0]; period = CW'(top); pol_mode = pol[1:0];
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; cmp_wr = 1'b1; cmp_data = CW'(cmp);
    endtask

    // one sweep run: R1 R2 R3 R4 R5 R7 R8 R10
    task automatic sweep_run(int dual, int top, int pol, int cmp);
        int first;
        logic w;
        start(dual, top, pol, cmp);
        first = (dual == 0) ? top + 1 : 2 * top + 1;
        #1;
        chk("R8 reset flag", ovf_flag, 0);
        for (int n = 1; n <= first + 2 * ((dual == 0) ? top + 1 : 2 * top); n++) begin
            @(negedge clk);
            cmp_wr = 1'b0;
            #1;
            if (n >= first) begin
                w = lvl(cnt_at(n, dual, top), cmp, dual, top, pol);
                chk(dual == 0 ? "R1 R3 R5 pins" : "R2 R4 R5 pins", pins,
                    exp_pins(w, pol, ovr_en, port_bits));
            end
            chk("R8 flag", ovf_flag,
                (dual == 0) ? int'(cnt_at(n - 1, dual, top) == top)
                            : int'((n - 1) > 0 && (n - 1) % (2 * top) == 0));
            chk("R10 irq", irq, ovf_flag);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                finish_up();
            end
        end
    end

    initial begin
        int tops[4] = '{1, 2, 3, 6};
        logic w;

        // reset state
        start(0, 3, 2, 0);
        rst_n = 1'b0;
        #1;
        @(negedge clk); #1;
        chk("R8 reset flag", ovf_flag, 0);
        chk("R7 reset compare zero pins", pins, 6'h00);

        // sweep
        for (int d = 0; d < 2; d++)
            for (int t = 0; t < 4; t++)
                for (int p = 1; p < 4; p++)
                    for (int c = 0; c <= tops[t] + 1; c++)
                        sweep_run(d, tops[t], p, c);

        // R5 polarity 00 disconnects
        start(0, 3, 0, 2);
        port_bits = 6'h2B;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk); cmp_wr = 1'b0; #1;
            chk("R5 pol00 pins", pins, 6'h2B);
        end

        // R6 per-pin override, immediate
        start(0, 3, 2, 2);
        for (int n = 1; n <= 24; n++) begin
            @(negedge clk); cmp_wr = 1'b0;
            ovr_en = 6'(n * 13); port_bits = 6'(n * 7 + 5);
            #1;
            if (n >= 4) begin
                w = lvl(cnt_at(n, 0, 3), 2, 0, 3, 2);
                chk("R6 override pins", pins, exp_pins(w, 2, ovr_en, port_bits));
                #2;
                ovr_en = ~ovr_en;
                #1;
                chk("R6 override instant", pins, exp_pins(w, 2, ovr_en, port_bits));
            end
        end

        // R7 compare buffering: write 4 mid-period, old value 2 stays until wrap
        start(0, 5, 2, 2);
        for (int n = 1; n <= 17; n++) begin
            @(negedge clk); cmp_wr = 1'b0; #1;
            if (n >= 8) begin
                w = lvl(cnt_at(n, 0, 5), (n <= 11) ? 2 : 4, 0, 5, 2);
                chk("R7 buffered compare", pins, exp_pins(w, 2, 6'h3F, 6'h00));
            end
            if (n == 7) begin cmp_wr = 1'b1; cmp_data = CW'(4); end
        end

        // R7 triangle: write 1 mid-period, old value 3 stays until bottom
        start(1, 4, 2, 3);
        for (int n = 1; n <= 24; n++) begin
            @(negedge clk); cmp_wr = 1'b0; #1;
            if (n >= 10) begin
                w = lvl(cnt_at(n, 1, 4), (n <= 16) ? 3 : 1, 1, 4, 2);
                chk("R7 buffered compare tri", pins, exp_pins(w, 2, 6'h3F, 6'h00));
            end
            if (n == 10) begin cmp_wr = 1'b1; cmp_data = CW'(1); end
        end

        // R9 sticky flag, R10 masking
        start(0, 3, 2, 1);
        ovf_clr = 1'b0; irq_en = 1'b0;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk); cmp_wr = 1'b0; ovf_clr = 1'b0; #1;
            case (n)
                3:  chk("R8 flag before top", ovf_flag, 0);
                4:  chk("R9 flag set", ovf_flag, 1);
                5:  begin chk("R9 flag sticky", ovf_flag, 1); chk("R10 irq masked", irq, 0); end
                6:  begin
                        irq_en = 1'b1; #1;
                        chk("R10 irq enable immediate", irq, 1);
                        ovf_clr = 1'b1;
                    end
                7:  begin chk("R9 flag cleared", ovf_flag, 0); chk("R10 irq low", irq, 0); end
                8:  chk("R8 flag again", ovf_flag, 1);
                11: ovf_clr = 1'b1;
                12: chk("R9 set wins over clear", ovf_flag, 1);
                default: ;
            endcase
        end

        finish_up();
    end
endmodule